// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned operands one bit per clock. A single start pulse loads both operands in parallel into shift registers and clears the carry flip-flop. On each of the following clock edges, one full-adder cell combines the two low bits and the stored carry. The sum bit goes into a result register, the new carry goes into the carry flip-flop, and both operand registers move one place toward bit 0. With the default width of 8, a complete addition takes 9 edges: 1 load edge and 8 add edges.

A mode input is sampled at the load edge and chooses where the sum goes. In separate mode the sum is built in a dedicated result register. In accumulate mode each sum bit enters the top of operand register A, so the finished sum sits in A and the result register is left alone. After the last add edge the final carry is reported as an overflow flag, and a one-cycle done pulse marks the end of the operation. While an addition runs, busy is high and new start pulses are ignored.

Top module: `serial_adder`

## Requirements
- R1: A start pulse sampled high at a clock edge while busy is low loads `opA` and `opB` and clears the carry. The first sum bit is therefore computed with a carry-in of 0.
- R2: Each add edge computes sum = a XOR b XOR c and carry = a·b + c·(a XOR b) on the current low operand bits. The sum bit enters the result at its MSB end, so after 8 add edges the first sum bit sits at bit 0.
- R3: `done` is high for exactly one cycle, directly after the ninth edge counted from the load edge (1 load edge + 8 add edges).
- R4: In separate mode (`accMode`=0 at load), when `done` is high, `sum` equals the low 8 bits of opA+opB. Example: 160+160 gives 64.
- R5: When `done` is high, `overflow` equals bit 8 of the 9-bit value opA+opB.
- R6: In accumulate mode (`accMode`=1 at load), `sum` shows operand register A, which holds the low 8 bits of opA+opB when `done` is high.
- R7: A start pulse while `busy` is high has no effect. The running addition completes with its original operands and produces no extra `done`.
- R8: A synchronous active-high reset drives `busy`, `done` and `overflow` to 0.
- R9: While idle with no start, `sum` and `overflow` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load pulse, accepted only while not busy |
| accMode | input | 1 | 1 selects accumulate-into-A mode, 0 selects separate result register |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| sum | output | WIDTH | Result: result register or register A, depending on the mode |
| overflow | output | 1 | Carry flip-flop, which holds the final carry after the last add edge |
| done | output | 1 | One-cycle pulse marking completion |
| busy | output | 1 | High during the eight add cycles |

## Verification
The embedded properties are checked on every cycle:
- the carry is clear after a load;
- the MSB of the result register takes the freshly computed sum bit;
- `done` is a single-cycle pulse that never coincides with `busy` and follows the last count;
- the carry and register A stay frozen while idle.

The correctness of the full 8-bit sum, the overflow bit in both modes, the exact 9-edge latency and the rejection of a start during busy are only visible through the bench's scenarios. These scenarios compare results against an independent 9-bit reference, including the 0+0 and 255+255 corners.

// File: rtl/serial_adder_pkg.sv
package serial_adder_pkg;
  typedef struct packed {
    logic load;     // parallel load of operands, carry clear
    logic shift;    // one add step
    logic accMode;  // latched result routing
  } serStrobe_t;
endpackage

// File: rtl/serial_adder_fa.sv
module serial_adder_fa (
  input  logic aBit,
  input  logic bBit,
  input  logic cIn,
  output logic sBit,
  output logic cOut
);
  logic halfSum;
  always_comb begin
    halfSum = aBit ^ bBit;
    sBit    = cIn ^ halfSum;
    cOut    = (aBit & bBit) | (cIn & halfSum);
  end
endmodule

// File: rtl/serial_adder_ctrl.sv
module serial_adder_ctrl
  import serial_adder_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       accMode,
  output serStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam int CNT_W = $clog2(WIDTH) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] stepCnt;
  logic             modeQ;
  logic             loadGo;

  assign loadGo = start & ~busy;

  always_comb begin
    strobe.load    = loadGo;
    strobe.shift   = busy;
    strobe.accMode = modeQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepCnt <= '0;
      modeQ   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (loadGo) begin
        busy    <= 1'b1;
        stepCnt <= '0;
        modeQ   <= accMode;
      end else if (busy) begin
        stepCnt <= stepCnt + 1'b1;
        if (stepCnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R3: completion pulse is a single cycle and never overlaps busy
  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R3: done only after the final counted step
  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (rst)
    !done ##1 done |-> $past(stepCnt) == LAST);
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> stepCnt <= LAST);
endmodule

// File: rtl/serial_adder_datapath.sv
module serial_adder_datapath
  import serial_adder_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  serStrobe_t       strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sum,
  output logic             overflow
);
  logic [WIDTH-1:0] regA, regB, resQ;
  logic             carryQ;
  logic             sumBit, carryNext;

  serial_adder_fa u_fa (
    .aBit (regA[0]),
    .bBit (regB[0]),
    .cIn  (carryQ),
    .sBit (sumBit),
    .cOut (carryNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carryQ <= 1'b0;
    end else if (strobe.load) begin
      carryQ <= 1'b0;
    end else if (strobe.shift) begin
      carryQ <= carryNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      regA <= opA;
      regB <= opB;
    end else if (strobe.shift) begin
      regA <= {(strobe.accMode ? sumBit : 1'b0), regA[WIDTH-1:1]};
      regB <= {1'b0, regB[WIDTH-1:1]};
      if (!strobe.accMode) begin
        resQ <= {sumBit, resQ[WIDTH-1:1]};
      end
    end
  end

  assign sum      = strobe.accMode ? regA : resQ;
  assign overflow = carryQ;

  // R1: carry is clear after a load
  assert_carry_clear_R1: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> !carryQ);
  // R2: the result MSB takes the freshly computed sum bit
  assert_result_msb_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe.shift && !strobe.load && !strobe.accMode) |=> resQ[WIDTH-1] == $past(sumBit));
  // R9: state holds while idle
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!strobe.load && !strobe.shift) |=> ($stable(carryQ) && $stable(regA)));
endmodule

// File: rtl/serial_adder.sv
module serial_adder
  import serial_adder_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             accMode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sum,
  output logic             overflow,
  output logic             done,
  output logic             busy
);
  serStrobe_t strobe;

  serial_adder_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .accMode (accMode),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done)
  );

  serial_adder_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .sum      (sum),
    .overflow (overflow)
  );
endmodule

// File: tb/serial_adder_tb.sv
module serial_adder_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, start, accMode;
  logic [W-1:0] opA, opB, sum;
  logic overflow, done, busy;

  always #10 clk = ~clk;  // 50 MHz

  serial_adder #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .accMode(accMode),
    .opA(opA), .opB(opB), .sum(sum), .overflow(overflow),
    .done(done), .busy(busy)
  );

  typedef struct {
    logic [W:0] expVal;
    logic       mode;
    int         startCyc;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // driver: waits for idle, pulses start, pushes expected item
  task automatic doAdd(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic mode, input bit poke);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    opA = a; opB = b; accMode = mode; start = 1'b1;
    it.expVal = {1'b0, a} + {1'b0, b};
    it.mode = mode;
    it.startCyc = cyc;
    expQ.push_back(it);
    @(negedge clk);
    start = 1'b0;
    opA = ~a; opB = ~b; accMode = ~mode;
    if (poke) begin  // R7: start while busy must be ignored
      repeat (3) @(negedge clk);
      opA = 8'h5A; opB = 8'hC3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // monitor: pops and compares on done
  bit prevDone = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prevDone) check(!done, "R3 done width", int'(done), 0);
      if (done) begin
        if (expQ.size() == 0) begin
          check(0, "R7 unexpected done", 1, 0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          check(cyc - it.startCyc == 9, "R3 latency", cyc - it.startCyc, 9);
          if (it.mode)
            check(sum == it.expVal[W-1:0], "R6 acc sum", int'(sum), int'(it.expVal[W-1:0]));
          else
            check(sum == it.expVal[W-1:0], "R4 R1 R2 sum", int'(sum), int'(it.expVal[W-1:0]));
          check(overflow == it.expVal[W], "R5 overflow", int'(overflow), int'(it.expVal[W]));
        end
      end
      prevDone = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [W-1:0] holdSum;
    logic         holdOv;
    rst = 1'b1; start = 1'b0; accMode = 1'b0; opA = '0; opB = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !overflow, "R8 reset state",
          int'({busy, done, overflow}), 0);
    rst = 1'b0;

    doAdd(8'd0,   8'd0,   1'b0, 0);
    doAdd(8'd255, 8'd255, 1'b0, 0);
    doAdd(8'd160, 8'd160, 1'b0, 0);  // 320 -> 64 with overflow
    doAdd(8'd106, 8'd108, 1'b0, 0);
    doAdd(8'd0,   8'd0,   1'b1, 0);
    doAdd(8'd255, 8'd255, 1'b1, 0);
    doAdd(8'd1,   8'd255, 1'b1, 0);
    doAdd(8'd77,  8'd33,  1'b0, 1);  // R7
    doAdd(8'd200, 8'd100, 1'b1, 1);  // R7
    for (int i = 0; i < 40; i++)
      doAdd(W'($urandom), W'($urandom), 1'(i % 2), 0);

    while (busy || expQ.size() != 0) @(negedge clk);
    // R9: outputs hold while idle
    holdSum = sum; holdOv = overflow;
    repeat (5) @(negedge clk);
    check(sum == holdSum, "R9 sum hold", int'(sum), int'(holdSum));
    check(overflow == holdOv, "R9 overflow hold", int'(overflow), int'(holdOv));

    doAdd(8'd250, 8'd10, 1'b0, 0);
    while (busy || expQ.size() != 0) @(negedge clk);
    holdSum = sum; holdOv = overflow;
    repeat (4) @(negedge clk);
    check(sum == holdSum && overflow == holdOv, "R9 hold after overflow",
          int'({overflow, sum}), int'({holdOv, holdSum}));
    check(expQ.size() == 0, "R7 queue drained", expQ.size(), 0);
    finish_run();
  end
endmodule